// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds a set of binary semaphores that two agents, called the left side and the right side, use to agree on who may touch a shared resource. Each side has its own port with a select, a semaphore index, a write strobe, an output enable, one write data bit and a 16-bit read bus. A side asks for a token by writing 0 to it and gives it back by writing 1. It then reads the token to learn whether it holds it.

Every semaphore keeps one request latch per side and an ownership state (free, left or right). A request made while the other side holds the token is kept pending. When the holder releases, the token passes straight to the waiting side. If no side is waiting, the token becomes free. Everything is synchronous to one clock. Reads capture the flag once, at the start of an access, and hold that value for as long as the access lasts.

Top module: `sema_token_unit`

## Requirements
- R1: There are 8 semaphores. A port selects one with address bits [2:0] and ignores every higher address bit. Semaphores are independent of each other.
- R2: A write is a clock edge with select=1 and write strobe=1. Only the data-in bit is used: 0 requests the token and 1 releases it. A write of 1 to a free token leaves it free.
- R3: A request for a free token grants it to that side. The flag is active low: the owner reads 0x0000 and the other side reads 0xFFFF. Read data is always the flag bit copied onto all 16 bits.
- R4: While one side owns a token, a write of 0 from the other side leaves the ownership unchanged and stores a pending request for that side.
- R5: When the owner writes 1 and the other side has a pending request, the other side becomes owner on that same edge. With no pending request, the token becomes free and both sides read 0xFFFF.
- R6: A read is active while select=1, output enable=1 and write strobe=0. On the first edge where the read is active, the flag state from before that edge is loaded onto the read bus. The bus then holds that value for as long as the read stays active, even if ownership changes.
- R7: On any edge where a side's read is inactive, that side's read bus goes to 0xFFFF.
- R8: If both sides request a free token on the same edge, the left side gets it and the right side's request stays pending.
- R9: After reset every token is free, no request is pending and both read buses show 0xFFFF.
- R10: A write of 1 from a side that neither owns the token nor has a pending request has no effect on that token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left semaphore select |
| l_addr_i | input | 16 | Left address; bits [2:0] pick the semaphore |
| l_wr_i | input | 1 | Left write strobe |
| l_oe_i | input | 1 | Left output enable |
| l_din0_i | input | 1 | Left write data bit |
| l_rdata_o | output | 16 | Left read data |
| r_sel_i | input | 1 | Right semaphore select |
| r_addr_i | input | 16 | Right address; bits [2:0] pick the semaphore |
| r_wr_i | input | 1 | Right write strobe |
| r_oe_i | input | 1 | Right output enable |
| r_din0_i | input | 1 | Right write data bit |
| r_rdata_o | output | 16 | Right read data |

## Verification
A corrupted ownership state or request latch does not show at the ports until a side starts a fresh read of that semaphore. The bad flag then appears on the read bus one edge after the read begins. A lost pending request shows only when the holder releases, because the waiting side then reads 0xFFFF instead of 0x0000. The bench therefore follows every write with reads from both sides. It also compares both read buses against a behavioural model after every clock edge, so a wrong capture or a failure to hold the value is caught within one cycle.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_req_i,
  input  logic [1:0] clr_req_i,
  output owner_e     own_o,
  output logic [1:0] flag_o
);
  logic [1:0] req_q, req_d;
  owner_e     own_q, own_d;

  assign req_d = (req_q | set_req_i) & ~clr_req_i;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_FREE: begin
        // left wins a same-edge tie
        if (req_d[SIDE_L])      own_d = OWN_LEFT;
        else if (req_d[SIDE_R]) own_d = OWN_RIGHT;
      end
      OWN_LEFT:  if (!req_d[SIDE_L]) own_d = req_d[SIDE_R] ? OWN_RIGHT : OWN_FREE;
      OWN_RIGHT: if (!req_d[SIDE_R]) own_d = req_d[SIDE_L] ? OWN_LEFT : OWN_FREE;
      default:   own_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      own_q <= OWN_FREE;
    end else begin
      req_q <= req_d;
      own_q <= own_d;
    end
  end

  assign own_o          = own_q;
  assign flag_o[SIDE_L] = (own_q != OWN_LEFT);
  assign flag_o[SIDE_R] = (own_q != OWN_RIGHT);
endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_act_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              act_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      data_q <= '1;
    end else begin
      act_q <= rd_act_i;
      if (rd_act_i && !act_q) data_q <= {DATA_W{flag_i}};
      else if (!rd_act_i)     data_q <= '1;
    end
  end

  assign rdata_o = data_q;
endmodule

// File: rtl/sema_token_unit.sv
module sema_token_unit
  import sema_pkg::*;
#(
  parameter int N_SEM  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wr_i,
  input  logic              l_oe_i,
  input  logic              l_din0_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sel_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wr_i,
  input  logic              r_oe_i,
  input  logic              r_din0_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int SEL_W = $clog2(N_SEM);

  logic [SEL_W-1:0] l_idx, r_idx;
  logic             l_wr_go, r_wr_go, l_rd_go, r_rd_go;
  logic             l_flag, r_flag;
  owner_e           own_w  [N_SEM];
  logic [1:0]       flag_w [N_SEM];
  logic             unused_addr_hi;

  assign l_idx   = l_addr_i[SEL_W-1:0];
  assign r_idx   = r_addr_i[SEL_W-1:0];
  assign l_wr_go = l_sel_i & l_wr_i;
  assign r_wr_go = r_sel_i & r_wr_i;
  assign l_rd_go = l_sel_i & l_oe_i & ~l_wr_i;
  assign r_rd_go = r_sel_i & r_oe_i & ~r_wr_i;
  assign unused_addr_hi = ^{l_addr_i[ADDR_W-1:SEL_W], r_addr_i[ADDR_W-1:SEL_W]};

  for (genvar k = 0; k < N_SEM; k++) begin : g_sem
    logic       l_hit, r_hit;
    logic [1:0] set_req, clr_req;
    assign l_hit = l_wr_go && (l_idx == SEL_W'(k));
    assign r_hit = r_wr_go && (r_idx == SEL_W'(k));
    assign set_req[SIDE_L] = l_hit & ~l_din0_i;
    assign clr_req[SIDE_L] = l_hit &  l_din0_i;
    assign set_req[SIDE_R] = r_hit & ~r_din0_i;
    assign clr_req[SIDE_R] = r_hit &  r_din0_i;

    sema_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_req_i (set_req),
      .clr_req_i (clr_req),
      .own_o     (own_w[k]),
      .flag_o    (flag_w[k])
    );
  end

  assign l_flag = flag_w[l_idx][SIDE_L];
  assign r_flag = flag_w[r_idx][SIDE_R];

  sema_rd_port #(.DATA_W(DATA_W)) u_rd_l (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (l_rd_go),
    .flag_i   (l_flag),
    .rdata_o  (l_rdata_o)
  );

  sema_rd_port #(.DATA_W(DATA_W)) u_rd_r (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (r_rd_go),
    .flag_i   (r_flag),
    .rdata_o  (r_rdata_o)
  );
endmodule

// File: rtl/sema_token_unit_chk.sv
module sema_token_unit_chk
  import sema_pkg::*;
#(
  parameter int N_SEM  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_sel_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_wr_i,
  input logic              l_oe_i,
  input logic              l_din0_i,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              r_sel_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_wr_i,
  input logic              r_oe_i,
  input logic              r_din0_i,
  input logic [DATA_W-1:0] r_rdata_o,
  input owner_e            own_i [N_SEM]
);
  localparam int SEL_W = $clog2(N_SEM);

  logic rd_l, rd_r;
  logic unused_chk_hi;
  assign rd_l = l_sel_i & l_oe_i & ~l_wr_i;
  assign rd_r = r_sel_i & r_oe_i & ~r_wr_i;
  assign unused_chk_hi = ^{l_addr_i[ADDR_W-1:SEL_W], r_addr_i[ADDR_W-1:SEL_W]};

  assert_repl_l_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rdata_o == '0) || (l_rdata_o == '1));
  assert_repl_r_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rdata_o == '0) || (r_rdata_o == '1));
  assert_hold_l_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_l && $past(rd_l)) |=> $stable(l_rdata_o));
  assert_hold_r_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_r && $past(rd_r)) |=> $stable(r_rdata_o));
  assert_idle_l_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_l |=> (l_rdata_o == '1));
  assert_idle_r_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_r |=> (r_rdata_o == '1));

  for (genvar k = 0; k < N_SEM; k++) begin : g_chk
    logic lw0, lw1, rw0, rw1;
    assign lw0 = l_sel_i && l_wr_i && (l_addr_i[SEL_W-1:0] == SEL_W'(k)) && !l_din0_i;
    assign lw1 = l_sel_i && l_wr_i && (l_addr_i[SEL_W-1:0] == SEL_W'(k)) &&  l_din0_i;
    assign rw0 = r_sel_i && r_wr_i && (r_addr_i[SEL_W-1:0] == SEL_W'(k)) && !r_din0_i;
    assign rw1 = r_sel_i && r_wr_i && (r_addr_i[SEL_W-1:0] == SEL_W'(k)) &&  r_din0_i;

    assert_keep_l_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[k] == OWN_LEFT && rw0 && !lw1) |=> (own_i[k] == OWN_LEFT));
    assert_keep_r_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[k] == OWN_RIGHT && lw0 && !rw1) |=> (own_i[k] == OWN_RIGHT));
    assert_pass_l_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[k] == OWN_LEFT && lw1 && rw0) |=> (own_i[k] == OWN_RIGHT));
    assert_pass_r_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[k] == OWN_RIGHT && rw1 && lw0) |=> (own_i[k] == OWN_LEFT));
    assert_tie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[k] == OWN_FREE && lw0 && rw0) |=> (own_i[k] == OWN_LEFT));
  end
endmodule

bind sema_token_unit sema_token_unit_chk #(
  .N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .l_sel_i   (l_sel_i),
  .l_addr_i  (l_addr_i),
  .l_wr_i    (l_wr_i),
  .l_oe_i    (l_oe_i),
  .l_din0_i  (l_din0_i),
  .l_rdata_o (l_rdata_o),
  .r_sel_i   (r_sel_i),
  .r_addr_i  (r_addr_i),
  .r_wr_i    (r_wr_i),
  .r_oe_i    (r_oe_i),
  .r_din0_i  (r_din0_i),
  .r_rdata_o (r_rdata_o),
  .own_i     (own_w)
);

// File: tb/sema_token_unit_tb_top.sv
module sema_token_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_sel = 0, l_wr = 0, l_oe = 0, l_din = 0;
  logic        r_sel = 0, r_wr = 0, r_oe = 0, r_din = 0;
  logic [15:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_rdata, r_rdata;

  int errors = 0;
  int checks = 0;

  // behavioural reference: 0 free, 1 left, 2 right
  int          m_own [8];
  bit          m_pl  [8];
  bit          m_pr  [8];
  bit          m_actl, m_actr;
  logic [15:0] m_exl, m_exr;

  always #5 clk = ~clk;

  sema_token_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_i(l_sel), .l_addr_i(l_addr), .l_wr_i(l_wr), .l_oe_i(l_oe),
    .l_din0_i(l_din), .l_rdata_o(l_rdata),
    .r_sel_i(r_sel), .r_addr_i(r_addr), .r_wr_i(r_wr), .r_oe_i(r_oe),
    .r_din0_i(r_din), .r_rdata_o(r_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin m_own[k] = 0; m_pl[k] = 0; m_pr[k] = 0; end
      m_actl = 0; m_actr = 0; m_exl = 16'hFFFF; m_exr = 16'hFFFF;
    end else begin
      int  kl, kr;
      bit  rdl, rdr;
      kl  = int'(l_addr[2:0]);
      kr  = int'(r_addr[2:0]);
      rdl = l_sel && l_oe && !l_wr;
      rdr = r_sel && r_oe && !r_wr;
      if (rdl && !m_actl) m_exl = (m_own[kl] == 1) ? 16'h0000 : 16'hFFFF;
      else if (!rdl)      m_exl = 16'hFFFF;
      if (rdr && !m_actr) m_exr = (m_own[kr] == 2) ? 16'h0000 : 16'hFFFF;
      else if (!rdr)      m_exr = 16'hFFFF;
      m_actl = rdl;
      m_actr = rdr;
      if (l_sel && l_wr) m_pl[kl] = !l_din;
      if (r_sel && r_wr) m_pr[kr] = !r_din;
      for (int k = 0; k < 8; k++) begin
        if (m_own[k] == 0) begin
          if (m_pl[k]) m_own[k] = 1;
          else if (m_pr[k]) m_own[k] = 2;
        end else if (m_own[k] == 1 && !m_pl[k]) m_own[k] = m_pr[k] ? 2 : 0;
        else if (m_own[k] == 2 && !m_pr[k]) m_own[k] = m_pl[k] ? 1 : 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (l_rdata !== m_exl) begin
        errors++;
        $display("FAIL R6 model left: actual=%h expected=%h", l_rdata, m_exl);
      end
      checks++;
      if (r_rdata !== m_exr) begin
        errors++;
        $display("FAIL R6 model right: actual=%h expected=%h", r_rdata, m_exr);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_wr = 0; l_oe = 0; l_din = 0;
    r_sel = 0; r_wr = 0; r_oe = 0; r_din = 0;
  endtask

  task automatic wr(input bit side, input logic [15:0] a, input bit d);
    if (!side) begin l_sel = 1; l_wr = 1; l_addr = a; l_din = d; end
    else       begin r_sel = 1; r_wr = 1; r_addr = a; r_din = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr2(input logic [15:0] a, input bit dl, input bit dr);
    l_sel = 1; l_wr = 1; l_addr = a; l_din = dl;
    r_sel = 1; r_wr = 1; r_addr = a; r_din = dr;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input bit side, input logic [15:0] a, output logic [15:0] v);
    if (!side) begin l_sel = 1; l_oe = 1; l_addr = a; end
    else       begin r_sel = 1; r_oe = 1; r_addr = a; end
    @(negedge clk);
    v = side ? r_rdata : l_rdata;
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R9 reset left bus", l_rdata, 16'hFFFF);
    check("R9 reset right bus", r_rdata, 16'hFFFF);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd(0, 16'(k), v); check("R9 all free left", v, 16'hFFFF);
    end

    // grant with upper address bits set
    wr(0, 16'hA5F0, 0);
    rd(0, 16'h0000, v); check("R1 R3 left owner reads 0", v, 16'h0000);
    rd(1, 16'h0000, v); check("R3 right non-owner reads 1", v, 16'hFFFF);
    rd(0, 16'h0001, v); check("R1 other semaphore untouched", v, 16'hFFFF);

    // pending request
    wr(1, 16'h0000, 0);
    rd(1, 16'h0000, v); check("R4 pending right still reads 1", v, 16'hFFFF);
    rd(0, 16'h0000, v); check("R4 left still owner", v, 16'h0000);

    // handover, then free
    wr(0, 16'h0000, 1);
    rd(1, 16'h0000, v); check("R5 right takes over", v, 16'h0000);
    rd(0, 16'h0000, v); check("R5 left released", v, 16'hFFFF);
    wr(1, 16'h0000, 1);
    rd(0, 16'h0000, v); check("R5 free left", v, 16'hFFFF);
    rd(1, 16'h0000, v); check("R5 free right", v, 16'hFFFF);

    // same-edge tie
    wr2(16'h0003, 0, 0);
    rd(0, 16'h0003, v); check("R8 tie left wins", v, 16'h0000);
    rd(1, 16'h0003, v); check("R8 tie right loses", v, 16'hFFFF);
    wr(0, 16'h0003, 1);
    rd(1, 16'h0003, v); check("R8 right request kept", v, 16'h0000);

    // stray release
    wr(0, 16'h0003, 1);
    rd(1, 16'h0003, v); check("R10 right keeps token", v, 16'h0000);
    rd(0, 16'h0003, v); check("R10 left gained nothing", v, 16'hFFFF);
    wr(1, 16'h0003, 1);

    // write 1 to free token
    wr(0, 16'h0005, 1);
    rd(0, 16'h0005, v); check("R2 write 1 keeps free", v, 16'hFFFF);
    wr(1, 16'h0005, 0);
    rd(0, 16'h0005, v); check("R2 free for right", v, 16'hFFFF);
    rd(1, 16'h0005, v); check("R2 right took it", v, 16'h0000);

    // independence
    wr(0, 16'h0001, 0);
    wr(1, 16'h0002, 0);
    rd(0, 16'h0001, v); check("R1 sem1 left", v, 16'h0000);
    rd(1, 16'h0002, v); check("R1 sem2 right", v, 16'h0000);
    rd(0, 16'h0002, v); check("R1 sem2 left", v, 16'hFFFF);

    // frozen read
    wr(1, 16'h0006, 0);
    wr(0, 16'h0006, 0);
    l_sel = 1; l_oe = 1; l_addr = 16'h0006;
    @(negedge clk);
    check("R6 capture", l_rdata, 16'hFFFF);
    r_sel = 1; r_wr = 1; r_addr = 16'h0006; r_din = 1;
    @(negedge clk);
    r_sel = 0; r_wr = 0; r_din = 0;
    @(negedge clk);
    check("R6 held after handover", l_rdata, 16'hFFFF);
    @(negedge clk);
    check("R6 still held", l_rdata, 16'hFFFF);
    l_sel = 0; l_oe = 0;
    @(negedge clk);
    check("R7 idle bus", l_rdata, 16'hFFFF);
    rd(0, 16'h0006, v); check("R6 fresh read sees ownership", v, 16'h0000);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule